// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire serial audio stream into parallel stereo samples. The stream is a bit clock, a word-select line and a data line. The block runs directly on the bit clock. A stereo frame is 64 bit clocks long, made of one 32-bit slot per channel.

Two configuration inputs control how a slot is read:
- `wlen_i` selects how many data bits the slot carries.
- `fmt_i` selects where those bits sit in the slot: at the start of the slot, at the end of the slot, or one bit after the word-select change (I2S).

Bits outside the data window are discarded. Each captured word is widened to a signed 24-bit value. A one-cycle strobe marks the moment a complete left/right pair is available.

The control path is a four-state machine, defined per sampled bit:

| State | Meaning |
|---|---|
| `PH_SYNC` | After reset. Slot alignment is not yet known. |
| `PH_LEAD` | Bit lies before the data window. |
| `PH_DATA` | Bit lies inside the data window and is shifted in. |
| `PH_TAIL` | Bit lies after the window, or the slot has overrun. |

Transitions:
- `PH_SYNC` stays in `PH_SYNC` until a word-select change is seen, then moves to the state that fits bit position 0.
- From any other state, every bit edge moves to `PH_LEAD`, `PH_DATA` or `PH_TAIL`, chosen from the new slot position against the window limits.
- A word-select change always restarts the position at 0, giving `*→LEAD` or `*→DATA`.
- The last bit of the window drives `DATA→LEAD`, `DATA→TAIL` or `DATA→DATA` (the last case only at a slot boundary).

Top module: `serial_audio_rx`

## Requirements
- R1: Reset behaviour.
  - While `rst_n` is low, `left_o` and `right_o` are zero and `valid_o` is low.
  - After reset, no bit is captured and no strobe is produced until word-select has been seen to change.
- R2: Slot position tracking.
  - The bit sampled on the rising edge at which `ws_i` differs from its previous sampled value is slot position 0.
  - Each later edge adds one to the position, which saturates at 63.
- R3: Word length encoding of `wlen_i`: 0 gives 16 bits, 1 gives 18 bits, 2 gives 20 bits, 3 gives 24 bits.
- R4: Front-aligned format (`fmt_i` = 0, and `fmt_i` = 3 behaves the same way): the MSB is at slot position 0 and the remaining bits follow MSB first.
- R5: Rear-aligned format (`fmt_i` = 1): the LSB is at slot position 31, so the MSB is at position 32 minus the word length.
- R6: I2S format (`fmt_i` = 2): the MSB is at slot position 1, and word-select low marks the left channel.
- R7: In formats 0, 1 and 3, word-select high marks the left channel.
- R8: Bits at slot positions outside the data window have no effect on the captured samples.
- R9: Each output word is the received value sign-extended from its word length to 24 bits. All bits at and above the received MSB position equal the received MSB.
- R10: Strobe behaviour.
  - `valid_o` pulses for exactly one cycle per frame, in the cycle in which `right_o` first shows the newly captured right word.
  - `left_o` does not change in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data and word-select are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws_i | input | 1 | Word-select (channel) line |
| sd_i | input | 1 | Serial data, MSB first |
| wlen_i | input | 2 | Word length code (R3) |
| fmt_i | input | 2 | Framing code (R4 to R6) |
| left_o | output | 24 | Sign-extended left sample |
| right_o | output | 24 | Sign-extended right sample |
| valid_o | output | 1 | One-cycle frame strobe |

## Verification
The assertions check on every cycle:
- that a word-select change restarts the slot position;
- that nothing is shifted in while still unsynchronised;
- that the strobe never lasts two cycles;
- that the left word holds still when the strobe fires;
- that every strobed right word is a correct sign extension.

Only the bench's frames can show that the MSB lands at the right position for each of the three framings and four word lengths, and that don't-care bits are truly ignored. The bench shows the latter by sending the same words with two different filler patterns. It also checks that each frame gives exactly one strobe, and that silence without a word-select change yields nothing after reset.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_LEAD = 2'd1,
        PH_DATA = 2'd2,
        PH_TAIL = 2'd3
    } phase_e;

    localparam logic [1:0] FMT_FRONT = 2'd0;
    localparam logic [1:0] FMT_REAR  = 2'd1;
    localparam logic [1:0] FMT_I2S   = 2'd2;

    // R3: word length code to bit count
    function automatic int unsigned word_bits(input logic [1:0] code);
        int unsigned n;
        unique case (code)
            2'd0: n = 16;
            2'd1: n = 18;
            2'd2: n = 20;
            default: n = 24;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/slot_tracker.sv
module slot_tracker
    import audio_rx_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 32,
    parameter int unsigned CNT_W     = $clog2(SLOT_BITS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ws_i,
    input  logic [1:0]       fmt_i,
    input  logic [1:0]       wlen_i,
    output logic             take_o,
    output logic             last_o,
    output logic             left_o,
    output phase_e           phase_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             ws_q;
    logic             primed_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] win_lo;
    logic [CNT_W-1:0] win_hi;
    logic [CNT_W-1:0] wbits;
    logic             ws_edge;
    phase_e           st_q;
    phase_e           st_d;

    assign ws_edge = primed_q && (ws_i != ws_q);
    assign wbits   = CNT_W'(word_bits(wlen_i));

    always_comb begin
        if (ws_edge)
            pos = '0;
        else if (cnt_q == CNT_MAX)
            pos = CNT_MAX;
        else
            pos = cnt_q + 1'b1;

        unique case (fmt_i)
            FMT_REAR: win_lo = CNT_W'(SLOT_BITS) - wbits;
            FMT_I2S:  win_lo = CNT_W'(1);
            default:  win_lo = '0;
        endcase
        win_hi = win_lo + wbits - 1'b1;
    end

    // next-state: classify the bit sampled at this edge
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_SYNC: begin
                if (ws_edge)
                    st_d = (pos < win_lo) ? PH_LEAD : PH_DATA;
            end
            PH_LEAD, PH_DATA, PH_TAIL: begin
                if (pos < win_lo)       st_d = PH_LEAD;
                else if (pos <= win_hi) st_d = PH_DATA;
                else                    st_d = PH_TAIL;
            end
            default: st_d = PH_SYNC;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= PH_SYNC;
            ws_q     <= 1'b0;
            primed_q <= 1'b0;
            cnt_q    <= CNT_MAX;
        end else begin
            st_q     <= st_d;
            ws_q     <= ws_i;
            primed_q <= 1'b1;
            cnt_q    <= pos;
        end
    end

    // outputs
    always_comb begin
        take_o  = (st_d == PH_DATA);
        last_o  = (st_d == PH_DATA) && (pos == win_hi);
        left_o  = (fmt_i == FMT_I2S) ? !ws_i : ws_i;
        phase_o = st_q;
    end

    AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && (ws_i != ws_q)) |=> (cnt_q == '0)); // R2

    AST_SYNC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == PH_SYNC) && !(primed_q && (ws_i != ws_q))) |-> !take_o); // R1

endmodule

// File: rtl/word_assembler.sv
module word_assembler
    import audio_rx_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sd_i,
    input  logic                take_i,
    input  logic                last_i,
    input  logic                left_i,
    input  logic [1:0]          wlen_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    logic [SAMPLE_W-1:0]        sh_q;
    logic [SAMPLE_W-1:0]        nw;
    logic signed [SAMPLE_W-1:0] aligned;
    logic [SAMPLE_W-1:0]        ext;
    int unsigned                pad;

    always_comb begin
        nw      = {sh_q[SAMPLE_W-2:0], sd_i};
        pad     = SAMPLE_W - word_bits(wlen_i);
        aligned = $signed(nw << pad);
        ext     = SAMPLE_W'(aligned >>> pad);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            left_o  <= '0;
            right_o <= '0;
            valid_o <= 1'b0;
        end else begin
            if (take_i)
                sh_q <= nw;
            if (last_i && left_i)
                left_o <= ext;
            if (last_i && !left_i)
                right_o <= ext;
            valid_o <= last_i && !left_i;
        end
    end

    logic signed [SAMPLE_W-1:0] top_bits;
    always_comb top_bits = $signed(right_o) >>> (word_bits(wlen_i) - 1);

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R10

    AST_LEFT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $stable(left_o)); // R10

    AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $stable(wlen_i)) |-> ((top_bits == '0) || (top_bits == '1))); // R9

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import audio_rx_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 32,
    parameter int unsigned SAMPLE_W  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ws_i,
    input  logic                sd_i,
    input  logic [1:0]          wlen_i,
    input  logic [1:0]          fmt_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    localparam int unsigned CNT_W = $clog2(SLOT_BITS) + 1;

    logic   take;
    logic   last;
    logic   is_left;
    phase_e phase;

    slot_tracker #(
        .SLOT_BITS (SLOT_BITS),
        .CNT_W     (CNT_W)
    ) i_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .ws_i    (ws_i),
        .fmt_i   (fmt_i),
        .wlen_i  (wlen_i),
        .take_o  (take),
        .last_o  (last),
        .left_o  (is_left),
        .phase_o (phase)
    );

    word_assembler #(
        .SAMPLE_W (SAMPLE_W)
    ) i_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sd_i    (sd_i),
        .take_i  (take),
        .last_i  (last),
        .left_i  (is_left),
        .wlen_i  (wlen_i),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    AST_DATA_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (phase != PH_SYNC)); // R1

endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ws_i = 1'b0;
    logic        sd_i = 1'b0;
    logic [1:0]  wlen_i = 2'd0;
    logic [1:0]  fmt_i = 2'd0;
    logic [23:0] left_o;
    logic [23:0] right_o;
    logic        valid_o;

    int n_chk = 0;
    int n_bad = 0;
    int vcnt = 0;
    logic [23:0] got_l = '0;
    logic [23:0] got_r = '0;

    always #2 clk = ~clk;

    serial_audio_rx i_serial_audio_rx (
        .clk(clk), .rst_n(rst_n), .ws_i(ws_i), .sd_i(sd_i),
        .wlen_i(wlen_i), .fmt_i(fmt_i),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    // fmt[52:51] wlen[50:49] L[48:25] R[24:1] filler[0]
    localparam logic [52:0] VEC [0:9] = '{
        {2'd0, 2'd0, 24'h001234, 24'h008001, 1'b0},
        {2'd0, 2'd0, 24'h001234, 24'h008001, 1'b1},
        {2'd1, 2'd1, 24'h02ABCD, 24'h015555, 1'b0},
        {2'd1, 2'd3, 24'h800000, 24'h7FFFFF, 1'b1},
        {2'd1, 2'd0, 24'h007FFF, 24'h00FFFF, 1'b1},
        {2'd2, 2'd2, 24'h080000, 24'h012345, 1'b0},
        {2'd2, 2'd3, 24'hA5A5A5, 24'h5A5A5A, 1'b1},
        {2'd0, 2'd2, 24'h0FFFFF, 24'h000001, 1'b0},
        {2'd3, 2'd1, 24'h020000, 24'h00ABCD, 1'b1},
        {2'd2, 2'd0, 24'h000001, 24'h008000, 1'b0}
    };

    always @(negedge clk) begin
        if (valid_o) begin
            vcnt  <= vcnt + 1;
            got_l <= left_o;
            got_r <= right_o;
        end
    end

    function automatic int wbits(input logic [1:0] c);
        return (c == 2'd0) ? 16 : (c == 2'd1) ? 18 : (c == 2'd2) ? 20 : 24;
    endfunction

    function automatic logic [23:0] sx(input logic [23:0] v, input int w);
        logic [23:0] r = v;
        for (int i = w; i < 24; i++) r[i] = v[w-1];
        return r;
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [1:0] f, input logic [1:0] wl,
                              input logic [23:0] l, input logic [23:0] r, input logic jp);
        int w = wbits(wl);
        int st = (f == 2'd1) ? 32 - w : (f == 2'd2) ? 1 : 0;
        logic lws = (f == 2'd2) ? 1'b0 : 1'b1;
        fmt_i  = f;
        wlen_i = wl;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            ws_i = ~lws;
            sd_i = jp;
        end
        vcnt = 0;
        for (int ch = 0; ch < 2; ch++) begin
            for (int p = 0; p < 32; p++) begin
                logic [23:0] word = (ch == 0) ? l : r;
                @(negedge clk);
                ws_i = (ch == 0) ? lws : ~lws;
                if (p >= st && p < st + w)
                    sd_i = word[w-1-(p-st)];
                else
                    sd_i = jp ^ p[0];
            end
        end
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        ws_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 left at reset", left_o, 24'h0);
        check("R1 right at reset", right_o, 24'h0);
        check("R1 valid at reset", {23'h0, valid_o}, 24'h0);
        rst_n = 1'b1;
        // R1: no word-select change, toggling data: nothing captured
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            sd_i = i[0];
        end
        #1;
        check("R1 no strobe before sync", 24'(vcnt), 24'd0);
        check("R1 right still zero", right_o, 24'h0);

        // table walk: R2..R10
        for (int i = 0; i < 10; i++) begin
            logic [52:0] v = VEC[i];
            int w = wbits(v[50:49]);
            send_frame(v[52:51], v[50:49], v[48:25], v[24:1], v[0]);
            check($sformatf("R4/R5/R6/R7 left vec%0d", i), got_l, sx(v[48:25], w));
            check($sformatf("R3/R9 right vec%0d", i), got_r, sx(v[24:1], w));
            check($sformatf("R10 one strobe vec%0d", i), 24'(vcnt), 24'd1);
        end

        // R8: same words, both filler patterns, rear 24-bit
        send_frame(2'd1, 2'd3, 24'h13579B, 24'hECA864, 1'b0);
        check("R8 filler0 left", got_l, 24'h13579B);
        send_frame(2'd1, 2'd3, 24'h13579B, 24'hECA864, 1'b1);
        check("R8 filler1 right", got_r, 24'hECA864);

        // R2: mid-slot resync, word-select change restarts position
        fmt_i = 2'd0; wlen_i = 2'd0;
        @(negedge clk); ws_i = 1'b0;
        repeat (10) @(negedge clk);
        send_frame(2'd0, 2'd0, 24'h00BEEF, 24'h000F0F, 1'b1);
        check("R2 resync left", got_l, 24'hFFBEEF);
        check("R2 resync right", got_r, 24'h000F0F);

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        #1;
        check("R1 left after reset", left_o, 24'h0);
        check("R1 valid after reset", {23'h0, valid_o}, 24'h0);
        finish_run();
    end

endmodule